// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state update that a 32-bit pipeline with a branch delay slot needs when it takes an exception. In any cycle the pipeline may present one request. A request carries a kind code, the faulting PC, the next PC, the bad virtual address, a coprocessor number and an address-space identifier. On the clock edge that accepts the request, the block does four things at once:

- It writes the system-control state: the exception-level flag, the exception PC, the cause fields, the bad-address register, the translation tags and the register-set control fields.
- It chooses the handler address.
- It loads the fetch redirect triple (PC, next PC, next-next PC).
- It raises a one-cycle redirect strobe.

Three configuration inputs are sampled as live levels: the exception base, the boot-vector flag and the interrupt-vector flag. The exception register-set number is a fourth such input. A synchronous reset applies the boot sequence.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads the boot sequence. `pc_o` becomes 0xBFC00000, `npc_o` becomes 0xBFC00004 and `nnpc_o` becomes 0xBFC00008. `st_cu1` becomes 1. `redirect`, `st_exl` and every other state output become 0.
- R2: Every accepted request sets `st_exl` to 1, whether or not it was already 1.
- R3: The request is in a delay slot when `req_pc`+4 differs from `req_npc`. In that case `epc_o` becomes `req_pc`-4 and `cause_bd` becomes 1. Otherwise `epc_o` becomes `req_pc` and `cause_bd` becomes 0.
- R4: `req_kind` encodes the request, and `cause_code` takes the value shown for each kind:

  | `req_kind` | Request | `cause_code` |
  |---|---|---|
  | 0 | interrupt | 0x0 |
  | 1 | TLB modified | 0x1 |
  | 2 | TLB invalid on load/fetch | 0x2 |
  | 3 | TLB invalid on store | 0x3 |
  | 4 | TLB refill on load/fetch | 0x2 |
  | 5 | TLB refill on store | 0x3 |
  | 6 | load address error | 0x4 |
  | 7 | store address error | 0x5 |
  | 8 | syscall | 0x8 |
  | 9 | breakpoint | 0x9 |
  | 10 | reserved instruction | 0xA |
  | 11 | coprocessor unusable | 0xB |
  | 12 | overflow | 0xC |
  | 13 | trap | 0xD |

- R5: A coprocessor-unusable request (kind 11) writes `req_cop` into `cause_ce`. Every other accepted kind clears `cause_ce`.
- R6: After an accepted request, `redirect` is 1 for exactly one cycle. `pc_o` holds the handler base, `npc_o` holds base+4 and `nnpc_o` holds base+8. Unless R7 to R9 say otherwise, the base is `cfg_ebase`+0x180.
- R7: Refill kinds (4 and 5) use `cfg_ebase`+0x000 when `st_exl` was 0 before the request, and `cfg_ebase`+0x180 when it was already 1.
- R8: An interrupt (kind 0) uses `cfg_ebase`+0x200 when `cfg_iv` is 1, and `cfg_ebase`+0x180 otherwise.
- R9: An overflow (kind 12) uses the fixed address 0xBFC00200 when `cfg_bev` is 1, and `cfg_ebase`+0x180 otherwise.
- R10: Kinds 1 to 7 load `badva_o` from `req_badva`. Kinds 1 to 5 also load `req_badva[31:13]` into both `ehi_vpn2` and `ctx_badvpn2`, and load `req_asid` into `ehi_asid`. All other kinds leave these outputs unchanged.
- R11: The register-set fields switch only when `st_exl` and `cfg_bev` are both 0 at entry. When they switch, `srs_pss` takes the old `srs_css` and `srs_css` takes `cfg_ess`. Otherwise both fields are unchanged.
- R12: A request is ignored when `req_valid` is 0 or when `req_kind` is 14 or 15. An ignored request leaves every state output unchanged and leaves `redirect` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (boot sequence) |
| req_valid | input | 1 | Exception request present this cycle |
| req_kind | input | 4 | Request kind code (see R4) |
| req_pc | input | 32 | PC of the faulting instruction |
| req_npc | input | 32 | Next PC at the fault |
| req_badva | input | 32 | Faulting virtual address |
| req_cop | input | 2 | Offending coprocessor number |
| req_asid | input | 8 | Address-space identifier of the access |
| cfg_ebase | input | 32 | Exception base address |
| cfg_bev | input | 1 | Boot-vector mode flag |
| cfg_iv | input | 1 | Dedicated interrupt vector enable |
| cfg_ess | input | 4 | Register set to use on exception entry |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| pc_o | output | 32 | Redirect PC |
| npc_o | output | 32 | Redirect next PC |
| nnpc_o | output | 32 | Redirect next-next PC |
| st_exl | output | 1 | Exception-level flag |
| st_cu1 | output | 1 | Coprocessor-1 usable flag |
| epc_o | output | 32 | Exception return PC |
| cause_code | output | 5 | Exception cause code |
| cause_bd | output | 1 | Delay-slot flag |
| cause_ce | output | 2 | Coprocessor number field |
| badva_o | output | 32 | Bad virtual address |
| ehi_vpn2 | output | 19 | Translation tag page pair number |
| ehi_asid | output | 8 | Translation tag address-space identifier |
| ctx_badvpn2 | output | 19 | Page-table context page pair number |
| srs_pss | output | 4 | Previous register set |
| srs_css | output | 4 | Current register set |

## Verification
Some rules can be checked on every cycle, and the assertions cover these:

- the boot values that follow reset;
- `st_exl` being 1 after every entry;
- the delay-slot rewind of the exception PC;
- the +4/+8 spacing of the redirect triple while the strobe is high;
- the state holding still when no request is accepted;
- the refill base when the pre-entry level is 0;
- the register-set fields freezing when `st_exl` or `cfg_bev` is already set.

Only the bench scenarios can show the per-kind cause table and the coprocessor field. The same is true of the choice between general, interrupt and boot overflow vectors, and of which kinds load the bad address and the translation tags. Those scenarios also follow the pre-entry level across back-to-back entries, with and without a reset in between.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN    = 32;
    localparam int KIND_W  = 4;
    localparam int CODE_W  = 5;
    localparam int COP_W   = 2;
    localparam int ASID_W  = 8;
    localparam int SRS_W   = 4;
    localparam int VPN_LSB = 13;
    localparam int VPN2_W  = XLEN - VPN_LSB;

    localparam logic [XLEN-1:0] INSN_BYTES = 32'd4;
    localparam logic [XLEN-1:0] BOOT_PC    = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] OVF_BOOT   = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] GEN_OFS    = 32'h0000_0180;
    localparam logic [XLEN-1:0] IRQ_OFS    = 32'h0000_0200;

    typedef enum logic [KIND_W-1:0] {
        K_IRQ       = 4'd0,
        K_TLB_MOD   = 4'd1,
        K_TLBI_LD   = 4'd2,
        K_TLBI_ST   = 4'd3,
        K_REFILL_LD = 4'd4,
        K_REFILL_ST = 4'd5,
        K_ADE_LD    = 4'd6,
        K_ADE_ST    = 4'd7,
        K_SYSCALL   = 4'd8,
        K_BREAK     = 4'd9,
        K_RESV      = 4'd10,
        K_COPU      = 4'd11,
        K_OVF       = 4'd12,
        K_TRAP      = 4'd13
    } exc_kind_e;

    typedef enum logic [1:0] {
        VEC_GEN,
        VEC_REFILL,
        VEC_IRQ,
        VEC_OVF
    } vec_sel_e;

    typedef struct packed {
        logic              legal;
        logic [CODE_W-1:0] code;
        vec_sel_e          vsel;
        logic              ld_bva;
        logic              ld_tlb;
        logic              ld_ce;
    } exc_class_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] nnpc;
    } redirect_t;

    function automatic exc_class_t classify(logic [KIND_W-1:0] k);
        exc_class_t c;
        c        = '0;
        c.vsel   = VEC_GEN;
        c.legal  = 1'b1;
        case (k)
            K_IRQ:       begin c.code = 5'h00; c.vsel = VEC_IRQ; end
            K_TLB_MOD:   begin c.code = 5'h01; c.ld_bva = 1'b1; c.ld_tlb = 1'b1; end
            K_TLBI_LD:   begin c.code = 5'h02; c.ld_bva = 1'b1; c.ld_tlb = 1'b1; end
            K_TLBI_ST:   begin c.code = 5'h03; c.ld_bva = 1'b1; c.ld_tlb = 1'b1; end
            K_REFILL_LD: begin c.code = 5'h02; c.ld_bva = 1'b1; c.ld_tlb = 1'b1;
                               c.vsel = VEC_REFILL; end
            K_REFILL_ST: begin c.code = 5'h03; c.ld_bva = 1'b1; c.ld_tlb = 1'b1;
                               c.vsel = VEC_REFILL; end
            K_ADE_LD:    begin c.code = 5'h04; c.ld_bva = 1'b1; end
            K_ADE_ST:    begin c.code = 5'h05; c.ld_bva = 1'b1; end
            K_SYSCALL:   c.code = 5'h08;
            K_BREAK:     c.code = 5'h09;
            K_RESV:      c.code = 5'h0A;
            K_COPU:      begin c.code = 5'h0B; c.ld_ce = 1'b1; end
            K_OVF:       begin c.code = 5'h0C; c.vsel = VEC_OVF; end
            K_TRAP:      c.code = 5'h0D;
            default:     c.legal = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/exc_decode.sv
module exc_decode
    import exc_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    output exc_class_t        cls
);
    always_comb cls = classify(kind);
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] GEN_OFFSET = GEN_OFS,
    parameter logic [XLEN-1:0] IRQ_OFFSET = IRQ_OFS,
    parameter logic [XLEN-1:0] OVF_FIXED  = OVF_BOOT
) (
    input  vec_sel_e        vsel,
    input  logic [XLEN-1:0] ebase,
    input  logic            exl_prev,
    input  logic            bev,
    input  logic            iv,
    output redirect_t       target
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] gen_base;

    assign gen_base = ebase + GEN_OFFSET;

    always_comb begin
        case (vsel)
            VEC_REFILL: base = exl_prev ? gen_base : ebase;
            VEC_IRQ:    base = iv ? (ebase + IRQ_OFFSET) : gen_base;
            VEC_OVF:    base = bev ? OVF_FIXED : gen_base;
            default:    base = gen_base;
        endcase
        target.pc   = base;
        target.npc  = base + INSN_BYTES;
        target.nnpc = base + (INSN_BYTES << 1);
    end
endmodule

// File: rtl/exc_cp0_regs.sv
module exc_cp0_regs
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  exc_class_t        cls,
    input  redirect_t         target,
    input  logic [XLEN-1:0]   req_pc,
    input  logic [XLEN-1:0]   req_npc,
    input  logic [XLEN-1:0]   req_badva,
    input  logic [COP_W-1:0]  req_cop,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              cfg_bev,
    input  logic [SRS_W-1:0]  cfg_ess,
    output logic              redirect_q,
    output redirect_t         pc_q,
    output logic              exl_q,
    output logic              cu1_q,
    output logic [XLEN-1:0]   epc_q,
    output logic [CODE_W-1:0] code_q,
    output logic              bd_q,
    output logic [COP_W-1:0]  ce_q,
    output logic [XLEN-1:0]   bva_q,
    output logic [VPN2_W-1:0] vpn2_q,
    output logic [ASID_W-1:0] asid_q,
    output logic [VPN2_W-1:0] ctx_vpn2_q,
    output logic [SRS_W-1:0]  pss_q,
    output logic [SRS_W-1:0]  css_q
);
    logic in_slot;
    logic srs_switch;

    assign in_slot    = (req_pc + INSN_BYTES) != req_npc;
    assign srs_switch = !exl_q && !cfg_bev;

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_q  <= 1'b0;
            pc_q.pc     <= BOOT_PC;
            pc_q.npc    <= BOOT_PC + INSN_BYTES;
            pc_q.nnpc   <= BOOT_PC + (INSN_BYTES << 1);
            exl_q       <= 1'b0;
            cu1_q       <= 1'b1;
            epc_q       <= '0;
            code_q      <= '0;
            bd_q        <= 1'b0;
            ce_q        <= '0;
            bva_q       <= '0;
            vpn2_q      <= '0;
            asid_q      <= '0;
            ctx_vpn2_q  <= '0;
            pss_q       <= '0;
            css_q       <= '0;
        end else begin
            redirect_q <= accept;
            if (accept) begin
                pc_q   <= target;
                exl_q  <= 1'b1;
                epc_q  <= in_slot ? (req_pc - INSN_BYTES) : req_pc;
                bd_q   <= in_slot;
                code_q <= cls.code;
                ce_q   <= cls.ld_ce ? req_cop : '0;
                if (cls.ld_bva) bva_q <= req_badva;
                if (cls.ld_tlb) begin
                    vpn2_q     <= req_badva[XLEN-1:VPN_LSB];
                    ctx_vpn2_q <= req_badva[XLEN-1:VPN_LSB];
                    asid_q     <= req_asid;
                end
                if (srs_switch) begin
                    pss_q <= css_q;
                    css_q <= cfg_ess;
                end
            end
        end
    end

    // R1
    boot_seq_chk: assert property (@(posedge clk)
        rst |=> (pc_q.pc == BOOT_PC && pc_q.nnpc == BOOT_PC + 32'd8 && cu1_q && !exl_q && !redirect_q));

    // R2
    exl_set_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> exl_q);

    // R3
    epc_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (bd_q == (($past(req_pc) + 32'd4) != $past(req_npc)))
                   && (epc_q == (bd_q ? $past(req_pc) - 32'd4 : $past(req_pc))));

    // R6
    redir_seq_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_q |-> (pc_q.npc == pc_q.pc + 32'd4 && pc_q.nnpc == pc_q.pc + 32'd8));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (!redirect_q && $stable(epc_q) && $stable(pc_q) && $stable(code_q) && $stable(css_q)));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [XLEN-1:0]   req_pc,
    input  logic [XLEN-1:0]   req_npc,
    input  logic [XLEN-1:0]   req_badva,
    input  logic [COP_W-1:0]  req_cop,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [XLEN-1:0]   cfg_ebase,
    input  logic              cfg_bev,
    input  logic              cfg_iv,
    input  logic [SRS_W-1:0]  cfg_ess,
    output logic              redirect,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   npc_o,
    output logic [XLEN-1:0]   nnpc_o,
    output logic              st_exl,
    output logic              st_cu1,
    output logic [XLEN-1:0]   epc_o,
    output logic [CODE_W-1:0] cause_code,
    output logic              cause_bd,
    output logic [COP_W-1:0]  cause_ce,
    output logic [XLEN-1:0]   badva_o,
    output logic [VPN2_W-1:0] ehi_vpn2,
    output logic [ASID_W-1:0] ehi_asid,
    output logic [VPN2_W-1:0] ctx_badvpn2,
    output logic [SRS_W-1:0]  srs_pss,
    output logic [SRS_W-1:0]  srs_css
);
    exc_class_t cls;
    redirect_t  target;
    redirect_t  pc_q;
    logic       accept;

    exc_decode u_decode (
        .kind (req_kind),
        .cls  (cls)
    );

    assign accept = req_valid && cls.legal;

    exc_vector u_vector (
        .vsel     (cls.vsel),
        .ebase    (cfg_ebase),
        .exl_prev (st_exl),
        .bev      (cfg_bev),
        .iv       (cfg_iv),
        .target   (target)
    );

    exc_cp0_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .cls        (cls),
        .target     (target),
        .req_pc     (req_pc),
        .req_npc    (req_npc),
        .req_badva  (req_badva),
        .req_cop    (req_cop),
        .req_asid   (req_asid),
        .cfg_bev    (cfg_bev),
        .cfg_ess    (cfg_ess),
        .redirect_q (redirect),
        .pc_q       (pc_q),
        .exl_q      (st_exl),
        .cu1_q      (st_cu1),
        .epc_q      (epc_o),
        .code_q     (cause_code),
        .bd_q       (cause_bd),
        .ce_q       (cause_ce),
        .bva_q      (badva_o),
        .vpn2_q     (ehi_vpn2),
        .asid_q     (ehi_asid),
        .ctx_vpn2_q (ctx_badvpn2),
        .pss_q      (srs_pss),
        .css_q      (srs_css)
    );

    assign pc_o   = pc_q.pc;
    assign npc_o  = pc_q.npc;
    assign nnpc_o = pc_q.nnpc;

    // R7
    refill_base_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_kind == K_REFILL_LD || req_kind == K_REFILL_ST) && !st_exl)
            |=> (pc_o == $past(cfg_ebase)));

    // R11
    srs_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (st_exl || cfg_bev)) |=> ($stable(srs_css) && $stable(srs_pss)));
endmodule

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;

    typedef struct packed {
        logic        rst_first;
        logic [3:0]  kind;
        logic [31:0] pc;
        logic [31:0] npc;
        logic [31:0] bad;
        logic [1:0]  cop;
        logic [7:0]  asid;
        logic [31:0] ebase;
        logic        bev;
        logic        iv;
        logic [3:0]  ess;
        logic [4:0]  exp_code;
        logic [31:0] exp_hdl;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd8,  32'h0040_0100, 32'h0040_0104, 32'h0, 2'd0, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 4'd3, 5'h08, 32'h8000_0180},
        '{1'b0, 4'd9,  32'h0040_0200, 32'h0040_0300, 32'h0, 2'd0, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 4'd5, 5'h09, 32'h8000_0180},
        '{1'b1, 4'd4,  32'h0000_1000, 32'h0000_1004, 32'h7FFF_E123, 2'd0, 8'h2A, 32'h8000_0000, 1'b0, 1'b0, 4'd2, 5'h02, 32'h8000_0000},
        '{1'b0, 4'd5,  32'h0000_1010, 32'h0000_1014, 32'h0040_2000, 2'd0, 8'h15, 32'h8000_0000, 1'b0, 1'b0, 4'd6, 5'h03, 32'h8000_0180},
        '{1'b1, 4'd0,  32'h0000_2000, 32'h0000_2004, 32'h0, 2'd0, 8'h00, 32'h8000_0000, 1'b0, 1'b1, 4'd1, 5'h00, 32'h8000_0200},
        '{1'b0, 4'd0,  32'h0000_2008, 32'h0000_200C, 32'h0, 2'd0, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 4'd1, 5'h00, 32'h8000_0180},
        '{1'b1, 4'd12, 32'h0000_2100, 32'h0000_2104, 32'h0, 2'd0, 8'h00, 32'h8000_0000, 1'b1, 1'b0, 4'd9, 5'h0C, 32'hBFC0_0200},
        '{1'b0, 4'd12, 32'h0000_2110, 32'h0000_2114, 32'h0, 2'd0, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 4'd9, 5'h0C, 32'h8000_0180},
        '{1'b1, 4'd11, 32'h0000_3000, 32'h0000_3004, 32'h0, 2'd2, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 4'd7, 5'h0B, 32'h8000_0180},
        '{1'b0, 4'd7,  32'h0000_3000, 32'h0000_3004, 32'h1234_5678, 2'd3, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 4'd7, 5'h05, 32'h8000_0180},
        '{1'b0, 4'd13, 32'h0000_3004, 32'h0000_3008, 32'h0, 2'd1, 8'h00, 32'h9000_0000, 1'b0, 1'b0, 4'd7, 5'h0D, 32'h9000_0180},
        '{1'b0, 4'd10, 32'h0000_3008, 32'h0000_3100, 32'h0, 2'd0, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 4'd7, 5'h0A, 32'h8000_0180},
        '{1'b0, 4'd1,  32'h0000_4000, 32'h0000_4004, 32'hC0DE_6000, 2'd0, 8'h77, 32'h8000_0000, 1'b0, 1'b0, 4'd7, 5'h01, 32'h8000_0180},
        '{1'b0, 4'd2,  32'h0000_4010, 32'h0000_4014, 32'h0BAD_A000, 2'd0, 8'h11, 32'h8000_0000, 1'b0, 1'b0, 4'd7, 5'h02, 32'h8000_0180},
        '{1'b0, 4'd3,  32'h0000_4020, 32'h0000_4024, 32'h5555_4000, 2'd0, 8'h22, 32'h8000_0000, 1'b0, 1'b0, 4'd7, 5'h03, 32'h8000_0180},
        '{1'b0, 4'd6,  32'h0000_4030, 32'h0000_4034, 32'hFFFF_FFF1, 2'd0, 8'h33, 32'h8000_0000, 1'b0, 1'b0, 4'd7, 5'h04, 32'h8000_0180}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic [31:0] req_pc = '0, req_npc = '0, req_badva = '0, cfg_ebase = 32'h8000_0000;
    logic [1:0]  req_cop = '0;
    logic [7:0]  req_asid = '0;
    logic        cfg_bev = 1'b0, cfg_iv = 1'b0;
    logic [3:0]  cfg_ess = '0;

    logic        redirect, st_exl, st_cu1, cause_bd;
    logic [31:0] pc_o, npc_o, nnpc_o, epc_o, badva_o;
    logic [4:0]  cause_code;
    logic [1:0]  cause_ce;
    logic [18:0] ehi_vpn2, ctx_badvpn2;
    logic [7:0]  ehi_asid;
    logic [3:0]  srs_pss, srs_css;

    int checks = 0;
    int failures = 0;

    logic        m_exl;
    logic [31:0] m_bva;
    logic [18:0] m_vpn;
    logic [7:0]  m_asid;
    logic [3:0]  m_pss, m_css;

    always #4 clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_pc(req_pc), .req_npc(req_npc), .req_badva(req_badva), .req_cop(req_cop),
        .req_asid(req_asid), .cfg_ebase(cfg_ebase), .cfg_bev(cfg_bev), .cfg_iv(cfg_iv),
        .cfg_ess(cfg_ess), .redirect(redirect), .pc_o(pc_o), .npc_o(npc_o),
        .nnpc_o(nnpc_o), .st_exl(st_exl), .st_cu1(st_cu1), .epc_o(epc_o),
        .cause_code(cause_code), .cause_bd(cause_bd), .cause_ce(cause_ce),
        .badva_o(badva_o), .ehi_vpn2(ehi_vpn2), .ehi_asid(ehi_asid),
        .ctx_badvpn2(ctx_badvpn2), .srs_pss(srs_pss), .srs_css(srs_css)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string vec_tag(input logic [3:0] k);
        case (k)
            4'd4, 4'd5: return "R7 refill base";
            4'd0:       return "R8 interrupt base";
            4'd12:      return "R9 overflow base";
            default:    return "R6 general base";
        endcase
    endfunction

    task automatic model_reset();
        m_exl = 1'b0; m_bva = '0; m_vpn = '0; m_asid = '0; m_pss = '0; m_css = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic check_boot();
        check("R1 pc", pc_o, 32'hBFC0_0000);
        check("R1 npc", npc_o, 32'hBFC0_0004);
        check("R1 nnpc", nnpc_o, 32'hBFC0_0008);
        check("R1 cu1", {31'd0, st_cu1}, 32'd1);
        check("R1 exl", {31'd0, st_exl}, 32'd0);
        check("R1 redirect", {31'd0, redirect}, 32'd0);
        check("R1 epc", epc_o, 32'd0);
        check("R1 srs", {24'd0, srs_pss, srs_css}, 32'd0);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic        slot;
        logic [31:0] exp_epc;
        logic        was_switch;
        logic [31:0] h_pc, h_epc;
        logic [4:0]  h_code;

        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_boot();

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rst_first) do_reset();
            req_valid = 1'b1;
            req_kind  = VECS[i].kind;
            req_pc    = VECS[i].pc;
            req_npc   = VECS[i].npc;
            req_badva = VECS[i].bad;
            req_cop   = VECS[i].cop;
            req_asid  = VECS[i].asid;
            cfg_ebase = VECS[i].ebase;
            cfg_bev   = VECS[i].bev;
            cfg_iv    = VECS[i].iv;
            cfg_ess   = VECS[i].ess;

            slot       = (VECS[i].pc + 32'd4) != VECS[i].npc;
            exp_epc    = slot ? VECS[i].pc - 32'd4 : VECS[i].pc;
            was_switch = !m_exl && !VECS[i].bev;
            if (was_switch) begin m_pss = m_css; m_css = VECS[i].ess; end
            m_exl = 1'b1;
            if (VECS[i].kind >= 4'd1 && VECS[i].kind <= 4'd7) m_bva = VECS[i].bad;
            if (VECS[i].kind >= 4'd1 && VECS[i].kind <= 4'd5) begin
                m_vpn  = VECS[i].bad[31:13];
                m_asid = VECS[i].asid;
            end

            @(negedge clk);
            req_valid = 1'b0;

            check("R6 redirect strobe", {31'd0, redirect}, 32'd1);
            check(vec_tag(VECS[i].kind), pc_o, VECS[i].exp_hdl);
            check("R6 npc", npc_o, VECS[i].exp_hdl + 32'd4);
            check("R6 nnpc", nnpc_o, VECS[i].exp_hdl + 32'd8);
            check("R4 cause code", {27'd0, cause_code}, {27'd0, VECS[i].exp_code});
            check("R3 epc", epc_o, exp_epc);
            check("R3 bd", {31'd0, cause_bd}, {31'd0, slot});
            check("R5 ce", {30'd0, cause_ce}, (VECS[i].kind == 4'd11) ? {30'd0, VECS[i].cop} : 32'd0);
            check("R2 exl", {31'd0, st_exl}, 32'd1);
            check("R10 badva", badva_o, m_bva);
            check("R10 vpn2", {13'd0, ehi_vpn2}, {13'd0, m_vpn});
            check("R10 ctx vpn2", {13'd0, ctx_badvpn2}, {13'd0, m_vpn});
            check("R10 asid", {24'd0, ehi_asid}, {24'd0, m_asid});
            check("R11 srs", {24'd0, srs_pss, srs_css}, {24'd0, m_pss, m_css});
        end

        // R6: the strobe lasts one cycle only
        @(negedge clk);
        check("R6 strobe drops", {31'd0, redirect}, 32'd0);

        // R12: kinds 14 and 15 with valid high change nothing
        h_pc = pc_o; h_epc = epc_o; h_code = cause_code;
        for (int k = 14; k < 16; k++) begin
            req_valid = 1'b1; req_kind = k[3:0];
            req_pc = 32'h0000_7000; req_npc = 32'h0000_9000; req_badva = 32'hDEAD_0000;
            @(negedge clk);
            req_valid = 1'b0;
            check("R12 illegal redirect", {31'd0, redirect}, 32'd0);
            check("R12 illegal pc", pc_o, h_pc);
            check("R12 illegal epc", epc_o, h_epc);
            check("R12 illegal code", {27'd0, cause_code}, {27'd0, h_code});
            check("R12 illegal badva", badva_o, m_bva);
        end

        // R12: a legal kind with valid low changes nothing
        req_valid = 1'b0; req_kind = 4'd8;
        @(negedge clk);
        check("R12 idle redirect", {31'd0, redirect}, 32'd0);
        check("R12 idle epc", epc_o, h_epc);

        // R7 and R11 after a fresh reset: refill with EXL clear, then repeat
        do_reset();
        check_boot();
        req_valid = 1'b1; req_kind = 4'd5; req_pc = 32'h0000_5000; req_npc = 32'h0000_5004;
        cfg_ebase = 32'hA000_0000; cfg_bev = 1'b0; cfg_ess = 4'd4;
        @(negedge clk);
        check("R7 refill exl0", pc_o, 32'hA000_0000);
        check("R11 css switched", {28'd0, srs_css}, 32'd4);
        req_kind = 4'd4; cfg_ess = 4'd8;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 refill exl1", pc_o, 32'hA000_0180);
        check("R11 css frozen", {28'd0, srs_css}, 32'd4);
        check("R11 pss frozen", {28'd0, srs_pss}, 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule